// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block resolves a virtual page number (VPN) and a process identifier (PID) into a physical page number (PPN). It uses a single inverted page table that every process shares. Each table entry carries its own VPN and PID tag. The walker folds the request into a table index, reads the entry that index selects and compares its tag with the request. On a mismatch it follows the entry's link field through the collision chain until one of three things happens: the tag matches, the chain ends, or a configurable entry budget runs out.

The table is normally sized at two to three times the number of physical frames, so most chains hold one or two entries. The walker issues one 32-bit read at a time on a plain request/acknowledge read port. Each entry costs two reads: the tag word, then the translation word. A new request is taken only while the walker is idle. Every request produces exactly one single-cycle response: a hit with its PPN, a plain miss, or a miss flagged as a budget overrun.

Top module: `hpt_walker`

## Requirements
- R1: While reset is high and after it is released, `resp_valid` and `mem_req` are 0 and `req_ready` is 1.
- R2: The first read of a walk targets `table_base + idx*8`, where idx is the low TBL_BITS bits of the VPN XORed with the PID zero-extended to 20 bits.
- R3: Each entry is two words. The tag word is read at the entry address and holds the VPN in bits 31:12 and the PID in bits PID_W-1:0. The translation word is read at the entry address plus 4 and holds the PPN in bits 31:12 and the link index in bits TBL_BITS-1:0.
- R4: An entry matches only when both its VPN and its PID equal the request. A match gives `resp_hit`=1 with that entry's PPN on `resp_ppn`. A VPN that is equal but has a different PID is not a match, and neither is a different VPN with an equal PID.
- R5: After a mismatch with a nonzero link, the next entry is read at `table_base + link*8`.
- R6: A mismatch whose link is 0 ends the walk with `resp_hit`=0 and `resp_limit`=0.
- R7: If MAX_CHAIN entries have been examined without a match and the last link is nonzero, the walk ends with `resp_hit`=0 and `resp_limit`=1, after exactly 2*MAX_CHAIN reads.
- R8: Once `mem_req` rises, it stays high with `mem_addr` unchanged until `mem_ack` is seen. Only one read is outstanding at a time.
- R9: A request is accepted only while `req_ready` is 1, and `req_ready` stays 0 until the walk ends. Each accepted request yields exactly one `resp_valid` pulse lasting one cycle.
- R10: A match found in entry number MAX_CHAIN of a chain is reported as a hit, not as a budget overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vpn | input | 20 | Virtual page number to translate |
| req_pid | input | PID_W | Process identifier of the request |
| table_base | input | AW | Byte address of entry 0 of the table |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | AW | Byte address of the word being read |
| mem_ack | input | 1 | Read data valid on this cycle |
| mem_rdata | input | 32 | Read data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Translation found |
| resp_limit | output | 1 | Miss caused by exceeding the chain budget |
| resp_ppn | output | 20 | Physical page number on a hit |

## Verification
Lookups are run against tables built to separate the cases the walker must tell apart: a match at the chain head, a match one link down, and an empty slot. Two near misses cover the match rule, one where the VPN agrees but the PID does not and one where the PID agrees but the VPN does not. At the chain budget, a cyclic chain must report an overrun after exactly twice the budget in reads. A chain of exactly budget length must still hit on its last entry, and the same chain with a mismatched tail must give a plain miss. The same index under two different table bases shows that the base register takes part in the address. The memory answers with varying latency, so the hold rule of the read port is exercised on every walk.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int VPN_W       = 20;
    localparam int PPN_W       = 20;
    localparam int WORD_W      = 32;
    localparam int ENTRY_SHIFT = 3;
    localparam int WORD_BYTES  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_LINK = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic             hit;
        logic             limit;
        logic [PPN_W-1:0] ppn;
    } walk_result_t;

    function automatic logic [VPN_W-1:0] word_page(input logic [WORD_W-1:0] w);
        return w[WORD_W-1 -: VPN_W];
    endfunction

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int PID_W    = 12,
    parameter int TBL_BITS = 10
) (
    input  logic [VPN_W-1:0]    vpn,
    input  logic [PID_W-1:0]    pid,
    output logic [TBL_BITS-1:0] idx
);
    logic [VPN_W-1:0] mix;

    always_comb begin
        mix = vpn ^ VPN_W'(pid);
        idx = mix[TBL_BITS-1:0];
    end
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
    import hpt_pkg::*;
#(
    parameter int AW       = 32,
    parameter int TBL_BITS = 10
) (
    input  logic [AW-1:0]       base,
    input  logic [TBL_BITS-1:0] idx,
    input  logic                second_word,
    output logic [AW-1:0]       addr
);
    localparam logic [AW-1:0] WORD_STEP = AW'(WORD_BYTES);

    logic [AW-1:0] entry_off;

    always_comb begin
        entry_off = AW'(idx) << ENTRY_SHIFT;
        addr      = base + entry_off + (second_word ? WORD_STEP : '0);
    end
endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp
    import hpt_pkg::*;
#(
    parameter int PID_W = 12
) (
    input  logic [WORD_W-1:0] tag_word,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [PID_W-1:0]  pid,
    output logic              match
);
    logic vpn_eq;
    logic pid_eq;

    always_comb begin
        vpn_eq = (word_page(tag_word) == vpn);
        pid_eq = (tag_word[PID_W-1:0] == pid);
        match  = vpn_eq && pid_eq;
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PID_W     = 12,
    parameter int TBL_BITS  = 10,
    parameter int MAX_CHAIN = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VPN_W-1:0]    req_vpn,
    input  logic [PID_W-1:0]    req_pid,
    input  logic [AW-1:0]       table_base,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                resp_valid,
    output logic                resp_hit,
    output logic                resp_limit,
    output logic [PPN_W-1:0]    resp_ppn
);
    localparam int CW = $clog2(MAX_CHAIN) + 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(MAX_CHAIN - 1);

    walk_state_e         state_q;
    logic [VPN_W-1:0]    vpn_q;
    logic [PID_W-1:0]    pid_q;
    logic [AW-1:0]       base_q;
    logic [TBL_BITS-1:0] idx_q;
    logic [CW-1:0]       cnt_q;
    logic                match_q;
    walk_result_t        res_q;
    logic                resp_valid_q;

    logic [TBL_BITS-1:0] head_idx;
    logic [TBL_BITS-1:0] link_idx;
    logic                tag_match;
    logic                accept;
    logic                word_ack;
    logic                unused_rdata;

    hpt_hash #(.PID_W(PID_W), .TBL_BITS(TBL_BITS)) u_hash (
        .vpn (req_vpn),
        .pid (req_pid),
        .idx (head_idx)
    );

    hpt_addr_gen #(.AW(AW), .TBL_BITS(TBL_BITS)) u_addr (
        .base        (base_q),
        .idx         (idx_q),
        .second_word (state_q == ST_LINK),
        .addr        (mem_addr)
    );

    hpt_entry_cmp #(.PID_W(PID_W)) u_cmp (
        .tag_word (mem_rdata),
        .vpn      (vpn_q),
        .pid      (pid_q),
        .match    (tag_match)
    );

    assign req_ready    = (state_q == ST_IDLE);
    assign mem_req      = (state_q == ST_TAG) || (state_q == ST_LINK);
    assign accept       = req_valid && req_ready;
    assign word_ack     = mem_ack && mem_req;
    assign link_idx     = mem_rdata[TBL_BITS-1:0];
    assign unused_rdata = ^mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            vpn_q        <= '0;
            pid_q        <= '0;
            base_q       <= '0;
            idx_q        <= '0;
            cnt_q        <= '0;
            match_q      <= 1'b0;
            res_q        <= '0;
            resp_valid_q <= 1'b0;
        end else begin
            resp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        vpn_q   <= req_vpn;
                        pid_q   <= req_pid;
                        base_q  <= table_base;
                        idx_q   <= head_idx;
                        cnt_q   <= '0;
                        state_q <= ST_TAG;
                    end
                end
                ST_TAG: begin
                    if (word_ack) begin
                        match_q <= tag_match;
                        state_q <= ST_LINK;
                    end
                end
                ST_LINK: begin
                    if (word_ack) begin
                        if (match_q) begin
                            res_q        <= '{hit: 1'b1, limit: 1'b0, ppn: word_page(mem_rdata)};
                            resp_valid_q <= 1'b1;
                            state_q      <= ST_IDLE;
                        end else if (link_idx == '0) begin
                            res_q        <= '{hit: 1'b0, limit: 1'b0, ppn: '0};
                            resp_valid_q <= 1'b1;
                            state_q      <= ST_IDLE;
                        end else if (cnt_q == LAST_CNT) begin
                            res_q        <= '{hit: 1'b0, limit: 1'b1, ppn: '0};
                            resp_valid_q <= 1'b1;
                            state_q      <= ST_IDLE;
                        end else begin
                            idx_q   <= link_idx;
                            cnt_q   <= cnt_q + 1'b1;
                            state_q <= ST_TAG;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_hit   = res_q.hit;
    assign resp_limit = res_q.limit;
    assign resp_ppn   = res_q.ppn;

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
    parameter int AW        = 32,
    parameter int MAX_CHAIN = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          resp_valid,
    input logic          resp_hit,
    input logic          resp_limit
);
    logic [15:0] acks_q;

    always_ff @(posedge clk) begin
        if (rst)
            acks_q <= '0;
        else if (req_valid && req_ready)
            acks_q <= '0;
        else if (mem_req && mem_ack)
            acks_q <= acks_q + 16'd1;
    end

    // R8: read request held with a stable address until acknowledged
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9: no acceptance while memory is in use
    a_r9_busy_while_walking: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R9: response strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R7: an overrun is never a hit
    a_r7_limit_is_miss: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_limit) |-> !resp_hit);

    // R7: every walk reads whole entries and never more than the budget
    a_r7_read_budget: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (acks_q >= 16'd2 && acks_q[0] == 1'b0
                         && acks_q <= 16'(2 * MAX_CHAIN)));

    // R7: overrun only after the whole budget was read
    a_r7_limit_reads: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_limit) |-> (acks_q == 16'(2 * MAX_CHAIN)));

endmodule

bind hpt_walker hpt_walker_chk #(.AW(AW), .MAX_CHAIN(MAX_CHAIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_limit (resp_limit)
);

// File: tb/tb_hpt_walker.sv
`timescale 1ns/1ps
module tb_hpt_walker;
    localparam int AW = 32, PID_W = 8, TBL_BITS = 6, MAX_CHAIN = 4;
    localparam logic [31:0] MEM_BASE = 32'h0000_4000;
    localparam logic [31:0] BASE_A   = 32'h0000_4000;
    localparam logic [31:0] BASE_B   = 32'h0000_4200;

    logic clk = 1'b0;
    logic rst;
    logic req_valid;
    logic req_ready;
    logic [19:0] req_vpn;
    logic [PID_W-1:0] req_pid;
    logic [AW-1:0] table_base;
    logic mem_req;
    logic [AW-1:0] mem_addr;
    logic mem_ack;
    logic [31:0] mem_rdata;
    logic resp_valid, resp_hit, resp_limit;
    logic [19:0] resp_ppn;

    always #2 clk = ~clk;

    hpt_walker #(.AW(AW), .PID_W(PID_W), .TBL_BITS(TBL_BITS), .MAX_CHAIN(MAX_CHAIN)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_pid(req_pid), .table_base(table_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_limit(resp_limit),
        .resp_ppn(resp_ppn)
    );

    logic [31:0] bmem [0:255];
    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    logic [31:0] first_addr = '0;
    int wait_cnt = 0;
    logic [7:0] lfsr = 8'h5A;
    int pulses = 0;
    int lookups = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rdw(input logic [31:0] a);
        logic [31:0] off;
        off = (a - MEM_BASE) >> 2;
        if (a < MEM_BASE || off > 255) return 32'h0;
        return bmem[off[7:0]];
    endfunction

    function automatic int hidx(input logic [19:0] vpn, input logic [7:0] pid);
        return int'((vpn ^ {12'h0, pid}) & 20'h3F);
    endfunction

    task automatic put(input logic [31:0] base, input int idx, input logic [19:0] vpn,
                       input logic [7:0] pid, input logic [19:0] ppn, input int link);
        int w;
        w = int'((base - MEM_BASE) >> 2) + idx * 2;
        bmem[w]     = {vpn, 4'h0, pid};
        bmem[w + 1] = {ppn, 6'h0, 6'(link)};
    endtask

    // behavioural reference walk over the bench memory
    task automatic ref_walk(input logic [31:0] base, input logic [19:0] vpn,
                            input logic [7:0] pid, output bit hit, output bit lim,
                            output logic [19:0] ppn, output int reads);
        int idx;
        bit done;
        logic [31:0] w0, w1;
        idx = hidx(vpn, pid);
        hit = 0; lim = 0; ppn = '0; reads = 0; done = 0;
        for (int n = 0; n < MAX_CHAIN && !done; n++) begin
            w0 = rdw(base + 32'(idx * 8));
            w1 = rdw(base + 32'(idx * 8 + 4));
            reads += 2;
            if (w0[31:12] == vpn && w0[7:0] == pid) begin
                hit = 1; ppn = w1[31:12]; done = 1;
            end else if (w1[5:0] == 6'd0) begin
                done = 1;
            end else begin
                idx = int'(w1[5:0]);
            end
        end
        if (!done) lim = 1;
    endtask

    // memory responder with varying latency
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt == 0) begin
                    if (rd_count == 0) first_addr = mem_addr;
                    rd_count++;
                    mem_rdata = rdw(mem_addr);
                    mem_ack = 1'b1;
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    wait_cnt = int'(lfsr[1:0]);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    always @(posedge clk) if (resp_valid) pulses++;

    task automatic lookup(input logic [31:0] base, input logic [19:0] vpn,
                          input logic [7:0] pid, input string rq);
        bit e_hit, e_lim;
        logic [19:0] e_ppn;
        int e_reads, n;
        logic [31:0] e_addr;
        ref_walk(base, vpn, pid, e_hit, e_lim, e_ppn, e_reads);
        e_addr = base + 32'(hidx(vpn, pid) * 8);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_count = 0;
        req_vpn = vpn; req_pid = pid; table_base = base; req_valid = 1'b1;
        lookups++;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R9 busy", 32'(req_ready), 32'h0);
        n = 0;
        while (!resp_valid && n < 300) begin @(negedge clk); n++; end
        check(resp_valid, {rq, " response"}, 32'(resp_valid), 32'h1);
        if (resp_valid) begin
            check(resp_hit == e_hit, {rq, " R4 hit"}, 32'(resp_hit), 32'(e_hit));
            check(resp_limit == e_lim, {rq, " R7 limit"}, 32'(resp_limit), 32'(e_lim));
            if (e_hit)
                check(resp_ppn == e_ppn, {rq, " R4 ppn"}, 32'(resp_ppn), 32'(e_ppn));
            check(rd_count == e_reads, {rq, " R5 reads"}, 32'(rd_count), 32'(e_reads));
            check(first_addr == e_addr, {rq, " R2 head address"}, first_addr, e_addr);
            @(negedge clk);
            check(!resp_valid, {rq, " R9 pulse"}, 32'(resp_valid), 32'h0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = '0;
        rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_pid = '0; table_base = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!resp_valid && !mem_req && req_ready, "R1 in reset",
              {29'h0, resp_valid, mem_req, req_ready}, 32'h1);
        rst = 1'b0;
        @(negedge clk);
        check(!resp_valid && !mem_req && req_ready, "R1 after reset",
              {29'h0, resp_valid, mem_req, req_ready}, 32'h1);

        // head hit, base A and B (R3 word layout)
        put(BASE_A, 1, 20'h12301, 8'h00, 20'hAAAA1, 0);
        put(BASE_B, 1, 20'h12301, 8'h00, 20'hF0F0F, 0);
        // two-entry chain (R5)
        put(BASE_A, 7, 20'h77707, 8'h05, 20'h11111, 40);
        put(BASE_A, 40, 20'h00402, 8'h05, 20'hBBBB2, 0);
        // PID differs at equal VPN
        put(BASE_A, 10, 20'h00403, 8'h0A, 20'h22222, 0);
        // VPN differs at equal PID
        put(BASE_A, 12, 20'h0050C, 8'h00, 20'hCCCC3, 0);
        // cyclic chain (R7)
        put(BASE_A, 20, 20'h99914, 8'h00, 20'h33333, 21);
        put(BASE_A, 21, 20'h99915, 8'h00, 20'h33334, 22);
        put(BASE_A, 22, 20'h99916, 8'h00, 20'h33335, 23);
        put(BASE_A, 23, 20'h99917, 8'h00, 20'h33336, 20);
        // budget-length chain (R10)
        put(BASE_A, 25, 20'h88819, 8'h00, 20'h44441, 26);
        put(BASE_A, 26, 20'h8881A, 8'h00, 20'h44442, 27);
        put(BASE_A, 27, 20'h8881B, 8'h00, 20'h44443, 28);
        put(BASE_A, 28, 20'h00019, 8'h00, 20'hEEEE4, 0);

        lookup(BASE_A, 20'h12301, 8'h00, "R4 head hit");
        lookup(BASE_B, 20'h12301, 8'h00, "R2 other base");
        lookup(BASE_A, 20'h00402, 8'h05, "R5 chain hit");
        lookup(BASE_A, 20'h77707, 8'h05, "R6 empty slot");
        lookup(BASE_A, 20'h00403, 8'h09, "R4 pid mismatch");
        lookup(BASE_A, 20'h0054C, 8'h00, "R4 vpn mismatch");
        lookup(BASE_A, 20'h0050C, 8'h00, "R3 hit");
        lookup(BASE_A, 20'h00014, 8'h00, "R7 loop overrun");
        lookup(BASE_A, 20'h00019, 8'h00, "R10 last entry hit");
        lookup(BASE_A, 20'h00059, 8'h00, "R6 budget tail miss");
        lookup(BASE_A, 20'h12301, 8'h00, "R8 repeat");

        repeat (4) @(negedge clk);
        check(pulses == lookups, "R9 pulse count", 32'(pulses), 32'(lookups));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule